// File: doc/BRIEF.md
# Shared Message Signaled Interrupt Unit

This block collects inbound message-signaled interrupt writes and holds them as pending flags in a small bank of shared interrupt registers. There are eight registers of 32 flags each, so up to 32 interrupt sources can share one register. A source posts an interrupt by writing a single index word. The top bits of that word name a register and the bit below them names a flag, and the addressed flag is set. Every register drives one interrupt line. The line is high while any of its flags is pending, unless software holds that line masked.

Software services a register by reading it. The read returns every pending flag of that register and clears them all in the same cycle. A source that posts into the register in that same cycle is not lost: its flag stays pending for the next read. Posting a flag that is already pending changes nothing, so repeated posts from one source merge into a single flag.

The register bus has separate write and read ports, and each port has its own word address. Read data is registered. The index register sits at word address NUM_REGS (8). The shared registers sit at word addresses 0 to NUM_REGS-1.

Top module: `msi_share_unit`

## Requirements
- R1: After reset every flag is clear, every `irq` bit is 0 and `bus_rd_data` is 0.
- R2: A write to word address 8 takes the register number from data bits [31:29] and the flag number from bits [28:24]. The edge that accepts the write sets that one flag and leaves every other flag unchanged.
- R3: Data bits [23:0] of an index write are ignored.
- R4: `irq[k]` is the OR of the flags of register k, forced to 0 while `irq_mask[k]` is 1. A masked register keeps its flags, and its line rises as soon as the mask is released.
- R5: A read at word address k (0 to 7) puts the flags of register k on `bus_rd_data` in the cycle after the read strobe. The same edge clears all flags of register k. In any cycle without a read, `bus_rd_data` is 0.
- R6: If an index write and a read target the same register in the same cycle, the read returns the flags held before that edge. Only the newly posted flag remains set afterwards.
- R7: Reads at word addresses 8 to 15 return 0. Writes to word addresses 0 to 7 have no effect on any flag.
- R8: Posting a flag that is already set has no further effect. One read after several posts to one bit shows that bit once, and the next read shows 0.
- R9: An index write to one register and a read of another register in the same cycle act independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_addr | input | 4 | Write word address |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe; a read of a shared register clears it |
| bus_rd_addr | input | 4 | Read word address |
| bus_rd_data | output | 32 | Registered read data, valid the cycle after the strobe |
| irq_mask | input | 8 | Per-register mask, 1 blocks the line |
| irq | output | 8 | Per-register interrupt lines |

## Verification
A wrong flag shows up on the `irq` line of its register in the cycle after the edge that stored it. It also shows up in full on the next read of that register, one cycle after the strobe. A clear that drops or keeps the wrong bits appears on the read that follows. The bench therefore reads a register back after every scenario, and then reads it again to confirm the clear. The collision cases check two things: that the returned word holds the old flags, and that the second read holds only the new one.

// File: rtl/msi_share_pkg.sv
package msi_share_pkg;
   localparam int unsigned MAX_REGS  = 64;
   localparam int unsigned MAX_FLAGS = 64;

   function automatic int unsigned field_top(input int unsigned lsb, input int unsigned w);
      return lsb + w - 1;
   endfunction
endpackage

// File: rtl/msi_index_decode.sv
module msi_index_decode #(
   parameter int unsigned NUM_REGS      = 8,
   parameter int unsigned FLAGS_PER_REG = 32,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned SEL_LSB       = 29,
   parameter int unsigned BIT_LSB       = 24
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   idx_wr,
   input  logic [DATA_W-1:0]                      idx_data,
   output logic [NUM_REGS-1:0][FLAGS_PER_REG-1:0] set_mat
);
   localparam int unsigned SEL_W = $clog2(NUM_REGS);
   localparam int unsigned BIT_W = $clog2(FLAGS_PER_REG);

   logic [SEL_W-1:0] sel;
   logic [BIT_W-1:0] bsel;

   assign sel  = idx_data[SEL_LSB +: SEL_W];
   assign bsel = idx_data[BIT_LSB +: BIT_W];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      for (genvar b = 0; b < FLAGS_PER_REG; b++) begin : g_bit
         assign set_mat[r][b] = idx_wr && (sel == SEL_W'(r)) && (bsel == BIT_W'(b));
      end
   end

   // R2: at most one flag is posted per index write
   p_single_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(set_mat) <= 1);
   // R2: an index write always posts exactly one flag
   p_write_posts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |-> $countones(set_mat) == 1);
endmodule

// File: rtl/msi_flag_bank.sv
module msi_flag_bank #(
   parameter int unsigned FLAGS_PER_REG = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [FLAGS_PER_REG-1:0] set_vec,
   input  logic                     clr,
   input  logic                     mask,
   output logic [FLAGS_PER_REG-1:0] flags,
   output logic                     irq
);
   logic [FLAGS_PER_REG-1:0] flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (clr) begin
         flags_q <= set_vec;
      end else begin
         flags_q <= flags_q | set_vec;
      end
   end

   assign flags = flags_q;
   assign irq   = (|flags_q) & ~mask;

   // R2: a posted flag is set after the edge
   p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
   // R5: a clearing read with no post empties the register
   p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && set_vec == '0) |=> (flags == '0));
   // R6: a clearing read that collides with a post leaves exactly one flag
   p_collide_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && set_vec != '0) |=> ($countones(flags) == 1));
   // R8: without a post or a clear the flags hold
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && set_vec == '0) |=> $stable(flags));
endmodule

// File: rtl/msi_read_port.sv
module msi_read_port #(
   parameter int unsigned NUM_REGS      = 8,
   parameter int unsigned FLAGS_PER_REG = 32,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned ADDR_W        = 4
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   rd_en,
   input  logic [ADDR_W-1:0]                      rd_addr,
   input  logic [NUM_REGS-1:0][FLAGS_PER_REG-1:0] flags,
   output logic [NUM_REGS-1:0]                    clr_vec,
   output logic [DATA_W-1:0]                      rd_data
);
   logic [FLAGS_PER_REG-1:0] sel_flags;
   logic [DATA_W-1:0]        rd_q;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
      assign clr_vec[r] = rd_en && (rd_addr == ADDR_W'(r));
   end

   always_comb begin
      sel_flags = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (clr_vec[r]) sel_flags = sel_flags | flags[r];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else begin
         rd_q <= DATA_W'(sel_flags);
      end
   end

   assign rd_data = rd_q;

   // R5: a read strobe clears at most one register
   p_one_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_vec));
   // R7: reads outside the shared registers return zero
   p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr >= ADDR_W'(NUM_REGS)) |=> (rd_data == '0));
   // R5: idle cycles return zero
   p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data == '0));
endmodule

// File: rtl/msi_share_unit.sv
module msi_share_unit #(
   parameter int unsigned NUM_REGS      = 8,
   parameter int unsigned FLAGS_PER_REG = 32,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned SEL_LSB       = 29,
   parameter int unsigned BIT_LSB       = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr_en,
   input  logic [ADDR_W-1:0]   bus_wr_addr,
   input  logic [DATA_W-1:0]   bus_wr_data,
   input  logic                bus_rd_en,
   input  logic [ADDR_W-1:0]   bus_rd_addr,
   output logic [DATA_W-1:0]   bus_rd_data,
   input  logic [NUM_REGS-1:0] irq_mask,
   output logic [NUM_REGS-1:0] irq
);
   import msi_share_pkg::*;

   localparam int unsigned SEL_W    = $clog2(NUM_REGS);
   localparam int unsigned BIT_W    = $clog2(FLAGS_PER_REG);
   localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(NUM_REGS);

   if (NUM_REGS < 2 || NUM_REGS > MAX_REGS || (1 << SEL_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two in range");
   end
   if (FLAGS_PER_REG < 2 || FLAGS_PER_REG > MAX_FLAGS || (1 << BIT_W) != FLAGS_PER_REG) begin : g_bad_flags
      $error("FLAGS_PER_REG must be a power of two in range");
   end
   if (FLAGS_PER_REG > DATA_W) begin : g_bad_data
      $error("flags do not fit in the data word");
   end
   if (field_top(SEL_LSB, SEL_W) >= DATA_W || field_top(BIT_LSB, BIT_W) >= SEL_LSB) begin : g_bad_fields
      $error("index fields overlap or exceed the data word");
   end
   if ((1 << ADDR_W) <= NUM_REGS) begin : g_bad_addr
      $error("ADDR_W too small for registers plus index word");
   end

   logic                                   idx_wr;
   logic [NUM_REGS-1:0][FLAGS_PER_REG-1:0] set_mat;
   logic [NUM_REGS-1:0][FLAGS_PER_REG-1:0] flags;
   logic [NUM_REGS-1:0]                    clr_vec;

   assign idx_wr = bus_wr_en && (bus_wr_addr == IDX_ADDR);

   msi_index_decode #(
      .NUM_REGS(NUM_REGS), .FLAGS_PER_REG(FLAGS_PER_REG), .DATA_W(DATA_W),
      .SEL_LSB(SEL_LSB), .BIT_LSB(BIT_LSB)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_data(bus_wr_data), .set_mat(set_mat)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_bank
      msi_flag_bank #(.FLAGS_PER_REG(FLAGS_PER_REG)) u_bank (
         .clk(clk), .rst_n(rst_n), .set_vec(set_mat[r]), .clr(clr_vec[r]),
         .mask(irq_mask[r]), .flags(flags[r]), .irq(irq[r])
      );

      // R4: a masked line stays low
      p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
         irq_mask[r] |-> !irq[r]);
      // R4: a post into an unmasked register raises its line
      p_post_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (set_mat[r] != '0 && !irq_mask[r]) |=> (irq[r] || irq_mask[r]));
   end

   msi_read_port #(
      .NUM_REGS(NUM_REGS), .FLAGS_PER_REG(FLAGS_PER_REG), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_read (
      .clk(clk), .rst_n(rst_n), .rd_en(bus_rd_en), .rd_addr(bus_rd_addr),
      .flags(flags), .clr_vec(clr_vec), .rd_data(bus_rd_data)
   );

   // R7: a write to a shared register address leaves the lines unchanged
   p_direct_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_wr_addr < IDX_ADDR && !bus_rd_en) |=> $stable(flags));
endmodule

// File: tb/msi_share_unit_bench.sv
module msi_share_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0;
   logic [3:0]  bus_wr_addr = '0;
   logic [31:0] bus_wr_data = '0;
   logic        bus_rd_en = 1'b0;
   logic [3:0]  bus_rd_addr = '0;
   logic [31:0] bus_rd_data;
   logic [7:0]  irq_mask = '0;
   logic [7:0]  irq;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   msi_share_unit u_msi_share_unit (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr),
      .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_addr(bus_rd_addr),
      .bus_rd_data(bus_rd_data), .irq_mask(irq_mask), .irq(irq)
   );

   function automatic logic [31:0] idx(input int sel, input int b);
      return {sel[2:0], b[4:0], 24'h0};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input bit we, input logic [3:0] wa, input logic [31:0] wd,
                      input bit re, input logic [3:0] ra);
      @(negedge clk);
      bus_wr_en = we; bus_wr_addr = wa; bus_wr_data = wd;
      bus_rd_en = re; bus_rd_addr = ra;
      @(negedge clk);
      bus_wr_en = 0; bus_rd_en = 0; bus_wr_data = '0;
   endtask

   task automatic post(input int sel, input int b);
      cyc(1, 4'd8, idx(sel, b), 0, 4'd0);
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      cyc(0, 4'd0, '0, 1, a);
      v = bus_rd_data;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 irq", {24'h0, irq}, 32'h0);
      check("R1 rdata", bus_rd_data, 32'h0);
      for (int r = 0; r < 8; r++) begin
         rd(r[3:0], v);
         check("R1 flags", v, 32'h0);
      end
   endtask

   task automatic t_basic();
      logic [31:0] v;
      post(3, 5);
      check("R2 irq", {24'h0, irq}, 32'h08);
      rd(4'd3, v);
      check("R5 read", v, 32'h20);
      check("R5 irq after clear", {24'h0, irq}, 32'h0);
      @(negedge clk);
      check("R5 idle rdata", bus_rd_data, 32'h0);
      rd(4'd3, v);
      check("R5 reread", v, 32'h0);
   endtask

   task automatic t_fields();
      logic [31:0] v;
      cyc(1, 4'd8, idx(1, 31) | 32'h00FF_FFFF, 0, 4'd0);
      post(7, 0);
      check("R3 irq", {24'h0, irq}, 32'h82);
      rd(4'd1, v);
      check("R3 reg1", v, 32'h8000_0000);
      rd(4'd7, v);
      check("R2 reg7", v, 32'h1);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      irq_mask = 8'h04;
      post(2, 9);
      check("R4 masked", {24'h0, irq}, 32'h0);
      @(negedge clk);
      irq_mask = 8'h00;
      #1;
      check("R4 unmasked", {24'h0, irq}, 32'h04);
      rd(4'd2, v);
      check("R4 flag kept", v, 32'h200);
   endtask

   task automatic t_coalesce();
      logic [31:0] v;
      post(4, 7); post(4, 7); post(4, 7); post(4, 8);
      rd(4'd4, v);
      check("R8 merged", v, 32'h180);
      rd(4'd4, v);
      check("R8 cleared", v, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      post(5, 1);
      cyc(1, 4'd8, idx(5, 2), 1, 4'd5);
      check("R6 old flags", bus_rd_data, 32'h2);
      check("R6 irq kept", {24'h0, irq}, 32'h20);
      rd(4'd5, v);
      check("R6 new survives", v, 32'h4);
   endtask

   task automatic t_other();
      logic [31:0] v;
      post(6, 3);
      cyc(1, 4'd8, idx(0, 10), 1, 4'd6);
      check("R9 read", bus_rd_data, 32'h8);
      rd(4'd0, v);
      check("R9 other reg", v, 32'h400);
      rd(4'd6, v);
      check("R9 cleared", v, 32'h0);
   endtask

   task automatic t_map();
      logic [31:0] v;
      post(7, 4);
      rd(4'd8, v);
      check("R7 index reads zero", v, 32'h0);
      for (int a = 9; a < 16; a++) begin
         rd(a[3:0], v);
         check("R7 unmapped", v, 32'h0);
      end
      cyc(1, 4'd7, 32'hFFFF_FFFF, 0, 4'd0);
      cyc(1, 4'd2, 32'hFFFF_FFFF, 0, 4'd0);
      check("R7 irq", {24'h0, irq}, 32'h80);
      rd(4'd7, v);
      check("R7 direct write", v, 32'h10);
      rd(4'd2, v);
      check("R7 direct write reg2", v, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_fields();
      t_mask();
      t_coalesce();
      t_collide();
      t_other();
      t_map();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule